// File: doc/BRIEF.md
# Table-Driven Clock Waveform Sequencer

This block plays back short waveform programs that open and close the clock switches of an image sensor and the control switches of its video chain. The programs sit in a small internal table that the host fills through a write port. Each program segment starts with a count word, and that many state words follow it.

A state word names one of three output banks and gives a switch pattern and a hold time. The sequencer loads the pattern into the named bank's register and keeps it there for the hold time before it steps to the next word. A start pulse names the address of the segment's count word. A one-cycle done pulse marks the end of the segment. One special word does not change any bank. Instead it raises a one-cycle request to send the converter result upstream.

Hold times come in two ranges, short and long. The long unit is a fixed multiple of the short one, and the short unit is a whole number of clock cycles.

Top module: `wfs_sequencer`

## Requirements
- R1: While reset is low, and after its release, every bank output (`video_sw`, `lower_sw`, `upper_sw`) is zero and `busy`, `done` and `adc_xmit` are low.
- R2: The word at the start address holds N, the number of state words that follow it. If start arrives while idle, the first state word is applied on the second rising edge after the accepting edge. After exactly N words, `done` is high for one cycle and `busy` falls in that same cycle. When N is 0, `done` comes on the second edge and no bank changes.
- R3: A state word is 24 bits. Bit 23 selects the long hold range, bits 22..16 hold the hold count, bits 15..12 name the bank, and bits 11..0 carry the switch pattern.
- R4: Bank 0 loads pattern bits 6..0 into `video_sw`. Bank 2 loads pattern bits 5..0 into `lower_sw`. Bank 3 loads pattern bits 4..0 into `upper_sw`. Any other bank value changes no output.
- R5: An applied word stays in force for count×SHORT_TICKS cycles in the short range and count×SHORT_TICKS×LONG_RATIO cycles in the long range. A count of 0 holds for one cycle. The next word, or `done`, takes effect exactly that many cycles later.
- R6: The exact word 0x00F041 changes no bank. It pulses `adc_xmit` high for the one cycle in which it is applied, and it holds for one cycle.
- R7: Bank outputs keep their last values while idle and across segments.
- R8: `busy` is high from the edge that accepts a start until the edge that raises `done`. A start seen while `busy` is high is ignored.
- R9: A write through `wr_en`/`wr_addr`/`wr_data` stores the word at that table address, and playback reads it from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table write address |
| wr_data | input | 24 | Table write data |
| start | input | 1 | Segment start request |
| start_addr | input | ADDR_W | Address of the segment's count word |
| video_sw | output | 7 | Video-chain switch bank |
| lower_sw | output | 6 | Serial, reset and summing-well switch bank |
| upper_sw | output | 5 | Parallel and transfer-gate switch bank |
| adc_xmit | output | 1 | One-cycle request to send the converter result |
| done | output | 1 | One-cycle end-of-segment pulse |
| busy | output | 1 | Segment playback in progress |

## Verification
The bench builds the block with ADDR_W=6, SHORT_TICKS=1 and LONG_RATIO=8. With these values one hold unit is one clock cycle, so the bench can sweep every hold count from 0 to 127 in both ranges, check each state boundary cycle by cycle, and still stay inside the cycle budget. A 64-word table leaves room for a mixed segment, a 16-word sweep segment and an empty segment at the same time. It also allows a start that is ignored to point at a segment that would visibly end early if it were wrongly accepted.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  localparam int WORD_W     = 24;
  localparam int HOLD_CNT_W = 7;
  localparam int BANK_W     = 4;
  localparam int PAT_W      = 12;
  localparam int HOLD_MAX   = (1 << HOLD_CNT_W) - 1;

  localparam logic [BANK_W-1:0] BANK_VIDEO = 4'd0;
  localparam logic [BANK_W-1:0] BANK_LOWER = 4'd2;
  localparam logic [BANK_W-1:0] BANK_UPPER = 4'd3;
  localparam logic [WORD_W-1:0] XMIT_WORD  = 24'h00F041;

  localparam int VIDEO_W = 7;
  localparam int LOWER_W = 6;
  localparam int UPPER_W = 5;

  typedef struct packed {
    logic                  long_rng;
    logic [HOLD_CNT_W-1:0] count;
    logic [BANK_W-1:0]     bank;
    logic [PAT_W-1:0]      pattern;
  } state_word_t;

  // Cycles a state stays in force; never less than one.
  function automatic int unsigned hold_cycles(input state_word_t w,
                                              input int unsigned short_ticks,
                                              input int unsigned long_ratio);
    int unsigned unit;
    int unsigned h;
    unit = w.long_rng ? short_ticks * long_ratio : short_ticks;
    h = 32'(w.count) * unit;
    return (h == 0) ? 1 : h;
  endfunction
endpackage

// File: rtl/wfs_table_mem.sv
module wfs_table_mem #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/wfs_bank_regs.sv
module wfs_bank_regs
  import wfs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply,
  input  state_word_t        word,
  output logic [VIDEO_W-1:0] video_sw,
  output logic [LOWER_W-1:0] lower_sw,
  output logic [UPPER_W-1:0] upper_sw,
  output logic               adc_xmit
);
  logic is_xmit;
  assign is_xmit = (word == state_word_t'(XMIT_WORD));

  logic [2:0] bank_hit;
  localparam logic [BANK_W-1:0] BANK_ID [3] = '{BANK_VIDEO, BANK_LOWER, BANK_UPPER};

  for (genvar g = 0; g < 3; g++) begin : g_hit
    assign bank_hit[g] = apply && !is_xmit && (word.bank == BANK_ID[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      video_sw <= '0;
      lower_sw <= '0;
      upper_sw <= '0;
      adc_xmit <= 1'b0;
    end else begin
      adc_xmit <= apply && is_xmit;
      if (bank_hit[0]) video_sw <= word.pattern[VIDEO_W-1:0];
      if (bank_hit[1]) lower_sw <= word.pattern[LOWER_W-1:0];
      if (bank_hit[2]) upper_sw <= word.pattern[UPPER_W-1:0];
    end
  end
endmodule

// File: rtl/wfs_seq_ctrl.sv
module wfs_seq_ctrl
  import wfs_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SHORT_TICKS = 4,
  parameter int LONG_RATIO  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              apply_evt,
  output logic              done,
  output logic              busy
);
  localparam int MAX_HOLD = HOLD_MAX * SHORT_TICKS * LONG_RATIO;
  localparam int CNT_W    = $clog2(MAX_HOLD + 1);
  localparam int LEN_W    = ADDR_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LEN, S_RUN} seq_state_t;

  seq_state_t        state;
  logic [ADDR_W-1:0] ptr;
  logic [LEN_W-1:0]  remain;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  hold_len;
  logic              step;
  logic              finish;

  assign hold_len  = CNT_W'(hold_cycles(state_word_t'(rd_data),
                                        SHORT_TICKS, LONG_RATIO));
  assign step      = (state == S_RUN) && (cnt == '0);
  assign apply_evt = step && (remain != '0);
  assign finish    = step && (remain == '0);
  assign busy      = (state != S_IDLE);
  assign rd_addr   = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      remain <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      case (state)
        S_IDLE: begin
          if (start) begin
            ptr   <= start_addr;
            state <= S_LEN;
          end
        end
        S_LEN: begin
          remain <= rd_data[LEN_W-1:0];
          ptr    <= ptr + 1'b1;
          cnt    <= '0;
          state  <= S_RUN;
        end
        S_RUN: begin
          if (finish) begin
            state <= S_IDLE;
          end else if (apply_evt) begin
            cnt    <= hold_len - 1'b1;
            ptr    <= ptr + 1'b1;
            remain <= remain - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wfs_sequencer.sv
module wfs_sequencer
  import wfs_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SHORT_TICKS = 4,
  parameter int LONG_RATIO  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [23:0]        wr_data,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  output logic [6:0]         video_sw,
  output logic [5:0]         lower_sw,
  output logic [4:0]         upper_sw,
  output logic               adc_xmit,
  output logic               done,
  output logic               busy
);
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic              apply_evt;

  wfs_table_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  wfs_seq_ctrl #(
    .ADDR_W      (ADDR_W),
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_RATIO  (LONG_RATIO)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .apply_evt  (apply_evt),
    .done       (done),
    .busy       (busy)
  );

  wfs_bank_regs u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (apply_evt),
    .word     (state_word_t'(rd_data)),
    .video_sw (video_sw),
    .lower_sw (lower_sw),
    .upper_sw (upper_sw),
    .adc_xmit (adc_xmit)
  );
endmodule

// File: rtl/wfs_sequencer_chk.sv
module wfs_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       adc_xmit,
  input logic       apply_evt,
  input logic [6:0] video_sw,
  input logic [5:0] lower_sw,
  input logic [4:0] upper_sw
);
  // R2: done is a single-cycle pulse that coincides with busy falling
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R4: banks move only on the edge after an apply event
  assert_bank_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_evt |=> ($stable(video_sw) && $stable(lower_sw) && $stable(upper_sw)));
  // R6: transmit request changes no bank and occurs only during playback
  assert_xmit_nochange_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_xmit |-> ($stable(video_sw) && $stable(lower_sw) && $stable(upper_sw)));
  assert_xmit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_xmit |-> busy);
  // R7: an idle cycle is followed by unchanged banks
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(video_sw) && $stable(lower_sw) && $stable(upper_sw)));
endmodule

bind wfs_sequencer wfs_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .adc_xmit  (adc_xmit),
  .apply_evt (apply_evt),
  .video_sw  (video_sw),
  .lower_sw  (lower_sw),
  .upper_sw  (upper_sw)
);

// File: tb/tb_wfs_sequencer.sv
`timescale 1ns/1ps
module tb_wfs_sequencer;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int LR    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [23:0]   wr_data = '0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [6:0]    video_sw;
  logic [5:0]    lower_sw;
  logic [4:0]    upper_sw;
  logic          adc_xmit, done, busy;

  wfs_sequencer #(.ADDR_W(AW), .SHORT_TICKS(1), .LONG_RATIO(LR)) dut (.*);

  always #5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit finished = 0;

  logic [23:0] tbmem [DEPTH];
  logic [6:0]  ev;
  logic [5:0]  el;
  logic [4:0]  eu;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      summary();
    end
  end

  function automatic logic [23:0] mk(input bit lg, input int cnt, input int bank, input int pat);
    return {lg, 7'(cnt), 4'(bank), 12'(pat)};
  endfunction

  // Hold length restated: short unit one cycle, long unit LR cycles, minimum one.
  function automatic int hold_of(input logic [23:0] w);
    int c;
    c = int'(w[22:16]);
    if (w[23]) c = c * LR;
    if (c < 1) c = 1;
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit xm, input bit bz, input bit dn);
    check(req, {14'd0, video_sw, lower_sw, upper_sw}, {14'd0, ev, el, eu});
    check(req, {29'd0, adc_xmit, busy, done}, {29'd0, xm, bz, dn});
  endtask

  task automatic wr(input int a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    tbmem[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic play(input int base, input bit inject);
    int n;
    int h;
    logic [23:0] w;
    bit xm;
    n = int'(tbmem[base][AW:0]);
    @(negedge clk);
    start = 1'b1; start_addr = AW'(base);
    @(negedge clk);
    start = 1'b0;
    check_all("R8 busy after start", 0, 1, 0);
    @(negedge clk);
    check_all("R2 count-word cycle", 0, 1, 0);
    for (int k = 0; k < n; k++) begin
      w = tbmem[(base + 1 + k) % DEPTH];
      @(negedge clk);
      start = 1'b0;
      xm = (w == 24'h00F041);
      if (!xm) begin
        case (int'(w[15:12]))
          0: ev = w[6:0];
          2: el = w[5:0];
          3: eu = w[4:0];
          default: ;
        endcase
      end
      check_all(xm ? "R6 xmit word" : "R4 bank apply", xm, 1, 0);
      if (inject && k == 0) begin
        start = 1'b1; start_addr = AW'(60);  // R8 ignored while busy
      end
      h = hold_of(w);
      for (int j = 1; j < h; j++) begin
        @(negedge clk);
        start = 1'b0;
        check_all("R5 hold", 0, 1, 0);
      end
    end
    @(negedge clk);
    start = 1'b0;
    check_all("R2 done end", 0, 0, 1);
    @(negedge clk);
    check_all("R2 done one cycle", 0, 0, 0);
  endtask

  initial begin
    ev = '0; el = '0; eu = '0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset", 0, 0, 0);

    // R9 table loaded through the write port; R3 field layout
    wr(40, 24'd9);
    wr(41, mk(0, 3, 2, 'h00D));
    wr(42, mk(0, 0, 0, 'h074));
    wr(43, mk(0, 2, 3, 'h013));
    wr(44, 24'h00F041);
    wr(45, mk(1, 2, 0, 'h05B));
    wr(46, mk(0, 1, 5, 'hFFF));
    wr(47, mk(0, 0, 2, 'hFF0));
    wr(48, mk(1, 1, 3, 'h01C));
    wr(49, mk(0, 0, 1, 'h003));
    wr(60, 24'd0);
    play(40, 0);

    // R7 empty segment leaves banks as they were
    play(60, 0);
    repeat (5) @(negedge clk);
    check_all("R7 idle retain", 0, 0, 0);

    // R5 sweep of every hold count in both ranges
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 8; b++) begin
        wr(0, 24'd16);
        for (int i = 0; i < 16; i++) begin
          int c;
          c = b * 16 + i;
          wr(1 + i, mk(r[0], c, (c % 3 == 0) ? 0 : ((c % 3 == 1) ? 2 : 3),
                       (c * 37 + r * 5 + 1) & 'hFFF));
        end
        play(0, 0);
      end
    end

    // R8 start during playback ignored
    play(40, 1);

    finished = 1;
    summary();
  end
endmodule